// File: doc/BRIEF.md
# FM/MFM Serial Write Encoder

This block turns a stream of bytes into the serial flux-cell sequence written to a floppy drive. Each data bit becomes a pair of cells: a clock cell followed by a data cell. In single-density (FM) mode every clock cell is a one. In double-density (MFM) mode a clock cell is a one only between two zero data bits. In MFM mode the block also flags each written one as early, late or nominal, so that an external delay stage can shift the pulse to offset peak shift on the media.

The host raises a write gate and hands over bytes through a valid/ready pair. The byte enters a one-deep holding register and is sent MSB first. A cell-rate enable pulse sets the pace. MFM emits one cell per pulse, and FM emits one cell per two pulses, so the same enable gives FM half the MFM cell rate. Writing begins once the gate is high and a byte is waiting. It ends at the next data-bit boundary after the gate falls. If the holding register is empty when a byte is needed, zero bits are sent in its place and a sticky error flag is raised.

Top module: `fmw_encoder`

## Requirements
- R1: While reset is high, every output is driven to 0 on the next clock edge: `wdata`, `wen`, `pre_early`, `pre_late`, `mfm_ind`, `underrun` and `byte_ready`.
- R2: In FM mode (`mode_mfm`=0), each data bit is sent MSB first as two cells: a clock cell of value 1, then a data cell equal to the bit.
- R3: In MFM mode (`mode_mfm`=1), each data bit is sent MSB first as a clock cell and then a data cell equal to the bit. The clock cell is 1 only when the previous data bit and the current data bit are both 0. The data bit written before the first bit of a write counts as 0.
- R4: `pre_early` and `pre_late` are both 0 on clock cells, on zero data cells and in FM mode. In MFM mode, a one data cell whose neighbouring data bits are 1 before and 0 after sets `pre_early`=1. Neighbours of 0 before and 1 after set `pre_late`=1. Every other pattern leaves both at 0.
- R5: In MFM mode the output advances one cell on every `cell_tick` pulse. In FM mode it advances one cell on every second pulse. The first cell appears on the first pulse after writing starts.
- R6: `wen` rises with the first cell of a write and stays high until the write ends. A write ends at the clock-cell boundary that follows the fall of `wr_go`, so the data bit in progress is finished. While `wen` is low, `wdata`, `pre_early` and `pre_late` are 0.
- R7: `mfm_ind` follows `mode_mfm` while idle, with two clock cycles of latency. The mode in force when a write starts is held for the whole write, and changes of `mode_mfm` during the write have no effect on the cells or on `mfm_ind`.
- R8: `byte_ready` is high only when `wr_go` was high in the previous cycle and the holding register is empty. A byte is taken on a cycle where `byte_valid` and `byte_ready` are both high. A write starts only when `wr_go` is high and a byte is held. Bytes held when `wr_go` is low are discarded.
- R9: If the next byte is needed while the holding register is empty, `underrun` goes to 1 and eight zero data bits are sent in its place. `underrun` then stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_go | input | 1 | Write gate from the host |
| mode_mfm | input | 1 | 1 selects MFM, 0 selects FM |
| cell_tick | input | 1 | Cell-rate enable, one clock wide |
| byte_data | input | BYTE_W | Byte to be written |
| byte_valid | input | 1 | `byte_data` is valid |
| byte_ready | output | 1 | Holding register can take a byte |
| wdata | output | 1 | Serial cell output, held for one cell |
| wen | output | 1 | High while cells are being written |
| mfm_ind | output | 1 | High for MFM, low for FM |
| pre_early | output | 1 | Current pulse should be shifted early |
| pre_late | output | 1 | Current pulse should be shifted late |
| underrun | output | 1 | Sticky byte-underrun flag |

## Verification
The assertions assume that reset is applied before the first gate, and that `cell_tick` pulses for one clock with at least two idle clocks between pulses. They also assume the host does not drop `byte_valid` before a byte is taken. The stimulus sends one tick every four clocks. It offers a byte only at a falling clock edge, holds it until `byte_ready` is seen, and supplies one padding byte after the payload so that the last bit has its lookahead. The underrun case is the only one where the bench deliberately withholds bytes.

// File: rtl/fmw_pkg.sv
package fmw_pkg;

  typedef enum logic [1:0] {
    PC_NOMINAL = 2'b00,
    PC_EARLY   = 2'b01,
    PC_LATE    = 2'b10
  } precomp_e;

  // Shift request for a written one, from its neighbouring data bits
  function automatic precomp_e precomp_of(input logic prv, input logic cur,
                                          input logic nxt);
    precomp_e r;
    r = PC_NOMINAL;
    if (cur && prv && !nxt) r = PC_EARLY;
    else if (cur && !prv && nxt) r = PC_LATE;
    return r;
  endfunction

endpackage

// File: rtl/fmw_byte_feed.sv
module fmw_byte_feed #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              gate,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              start,
  input  logic              pull,
  output logic              hold_full,
  output logic              first_c,
  output logic              first_n,
  output logic              next_bit,
  output logic              underrun
);
  localparam int LW = (BYTE_W > 2) ? $clog2(BYTE_W) : 1;
  localparam logic [LW-1:0] LAST_IDX = LW'(BYTE_W - 1);
  localparam logic [LW-1:0] START_LEFT = LW'(BYTE_W - 2);

  logic [BYTE_W-1:0] hold_q;
  logic [BYTE_W-1:0] sh_q;
  logic [LW-1:0]     left_q;
  logic              full_q;
  logic              accept_q;
  logic              urun_q;
  logic              take;
  logic              byte_end;
  logic              consume;

  assign in_ready  = accept_q & ~full_q;
  assign take      = in_valid & in_ready;
  assign byte_end  = pull & (left_q == '0);
  assign consume   = start | (byte_end & full_q);
  assign hold_full = full_q;
  assign underrun  = urun_q;
  assign first_c   = hold_q[BYTE_W-1];
  assign first_n   = hold_q[BYTE_W-2];
  assign next_bit  = (left_q == '0) ? (full_q & hold_q[BYTE_W-1])
                                    : sh_q[BYTE_W-1];

  // Holding register and its handshake
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q   <= '0;
      full_q   <= 1'b0;
      accept_q <= 1'b0;
    end else begin
      accept_q <= gate;
      if (!gate) begin
        full_q <= 1'b0;
      end else if (consume) begin
        full_q <= 1'b0;
      end else if (take) begin
        hold_q <= in_data;
        full_q <= 1'b1;
      end
    end
  end

  // Bit shifter feeding the lookahead window
  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      left_q <= '0;
      urun_q <= 1'b0;
    end else if (start) begin
      sh_q   <= hold_q << 2;
      left_q <= START_LEFT;
    end else if (pull) begin
      if (left_q != '0) begin
        sh_q   <= sh_q << 1;
        left_q <= left_q - 1'b1;
      end else if (full_q) begin
        sh_q   <= hold_q << 1;
        left_q <= LAST_IDX;
      end else begin
        sh_q   <= '0;
        left_q <= LAST_IDX;
        urun_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/fmw_cell_timer.sv
module fmw_cell_timer #(
  parameter int FM_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic tick,
  input  logic mfm,
  output logic step
);
  localparam int CW = (FM_DIV > 1) ? $clog2(FM_DIV) : 1;
  localparam logic [CW-1:0] WRAP = CW'(FM_DIV - 1);

  logic [CW-1:0] cnt_q;

  assign step = tick & (mfm | (cnt_q == '0));

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q <= '0;
    end else if (tick && !mfm) begin
      cnt_q <= (cnt_q == WRAP) ? '0 : cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/fmw_cell_coder.sv
module fmw_cell_coder
  import fmw_pkg::*;
#(
  parameter bit PRECOMP_EN = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_go,
  input  logic mode_in,
  input  logic can_start,
  input  logic first_c,
  input  logic first_n,
  input  logic next_bit,
  input  logic step,
  output logic start,
  output logic pull,
  output logic mode_run,
  output logic wdata,
  output logic wen,
  output logic pre_early,
  output logic pre_late,
  output logic mfm_ind
);
  logic     run_q, half_q, mode_q;
  logic     p_q, c_q, n_q;
  logic     clk_bit;
  precomp_e pc;

  assign start    = ~run_q & wr_go & can_start;
  assign pull     = run_q & step & half_q;
  assign mode_run = mode_q;
  assign clk_bit  = mode_q ? (~p_q & ~c_q) : 1'b1;

  generate
    if (PRECOMP_EN) begin : g_pc
      assign pc = mode_q ? precomp_of(p_q, c_q, n_q) : PC_NOMINAL;
    end else begin : g_nopc
      assign pc = PC_NOMINAL;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q     <= 1'b0;
      half_q    <= 1'b0;
      mode_q    <= 1'b0;
      p_q       <= 1'b0;
      c_q       <= 1'b0;
      n_q       <= 1'b0;
      wdata     <= 1'b0;
      wen       <= 1'b0;
      pre_early <= 1'b0;
      pre_late  <= 1'b0;
      mfm_ind   <= 1'b0;
    end else begin
      mfm_ind <= mode_q;
      if (!run_q) mode_q <= mode_in;
      if (start) begin
        run_q  <= 1'b1;
        half_q <= 1'b0;
        p_q    <= 1'b0;
        c_q    <= first_c;
        n_q    <= first_n;
      end else if (run_q && step) begin
        if (!half_q) begin
          pre_early <= 1'b0;
          pre_late  <= 1'b0;
          if (!wr_go) begin
            run_q <= 1'b0;
            wen   <= 1'b0;
            wdata <= 1'b0;
          end else begin
            wdata  <= clk_bit;
            wen    <= 1'b1;
            half_q <= 1'b1;
          end
        end else begin
          wdata     <= c_q;
          pre_early <= (pc == PC_EARLY);
          pre_late  <= (pc == PC_LATE);
          half_q    <= 1'b0;
          p_q       <= c_q;
          c_q       <= n_q;
          n_q       <= next_bit;
        end
      end
    end
  end

endmodule

// File: rtl/fmw_encoder.sv
module fmw_encoder #(
  parameter int BYTE_W     = 8,
  parameter int FM_DIV     = 2,
  parameter bit PRECOMP_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_go,
  input  logic              mode_mfm,
  input  logic              cell_tick,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              byte_valid,
  output logic              byte_ready,
  output logic              wdata,
  output logic              wen,
  output logic              mfm_ind,
  output logic              pre_early,
  output logic              pre_late,
  output logic              underrun
);
  logic start, pull, hold_full, first_c, first_n, next_bit;
  logic step, mode_run;

  fmw_byte_feed #(.BYTE_W(BYTE_W)) u_feed (
    .clk(clk), .rst(rst), .gate(wr_go),
    .in_data(byte_data), .in_valid(byte_valid), .in_ready(byte_ready),
    .start(start), .pull(pull), .hold_full(hold_full),
    .first_c(first_c), .first_n(first_n), .next_bit(next_bit),
    .underrun(underrun)
  );

  fmw_cell_timer #(.FM_DIV(FM_DIV)) u_timer (
    .clk(clk), .rst(rst), .restart(start), .tick(cell_tick),
    .mfm(mode_run), .step(step)
  );

  fmw_cell_coder #(.PRECOMP_EN(PRECOMP_EN)) u_coder (
    .clk(clk), .rst(rst), .wr_go(wr_go), .mode_in(mode_mfm),
    .can_start(hold_full), .first_c(first_c), .first_n(first_n),
    .next_bit(next_bit), .step(step), .start(start), .pull(pull),
    .mode_run(mode_run), .wdata(wdata), .wen(wen),
    .pre_early(pre_early), .pre_late(pre_late), .mfm_ind(mfm_ind)
  );

endmodule

// File: rtl/fmw_encoder_chk.sv
module fmw_encoder_chk (
  input logic clk,
  input logic rst,
  input logic wr_go,
  input logic byte_ready,
  input logic wdata,
  input logic wen,
  input logic mfm_ind,
  input logic pre_early,
  input logic pre_late,
  input logic underrun
);
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (!wen && !wdata && !pre_early && !pre_late && !underrun
             && !byte_ready && !mfm_ind));

  assert_shift_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
    !(pre_early && pre_late));

  assert_shift_on_mfm_one_R4: assert property (@(posedge clk) disable iff (rst)
    (pre_early || pre_late) |-> (mfm_ind && wdata && wen));

  assert_quiet_when_off_R6: assert property (@(posedge clk) disable iff (rst)
    !wen |-> (!wdata && !pre_early && !pre_late));

  assert_mode_held_R7: assert property (@(posedge clk) disable iff (rst)
    (wen && $past(wen)) |-> $stable(mfm_ind));

  assert_ready_needs_gate_R8: assert property (@(posedge clk) disable iff (rst)
    byte_ready |-> $past(wr_go));

  assert_underrun_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    underrun |=> underrun);

endmodule

bind fmw_encoder fmw_encoder_chk u_chk (
  .clk(clk), .rst(rst), .wr_go(wr_go), .byte_ready(byte_ready),
  .wdata(wdata), .wen(wen), .mfm_ind(mfm_ind), .pre_early(pre_early),
  .pre_late(pre_late), .underrun(underrun)
);

// File: tb/fmw_encoder_bench.sv
module fmw_encoder_bench;
  logic clk = 1'b0, rst = 1'b1, wr_go = 1'b0, mode_mfm = 1'b0, cell_tick = 1'b0;
  logic [7:0] byte_data = '0;
  logic byte_valid = 1'b0;
  logic byte_ready, wdata, wen, mfm_ind, pre_early, pre_late, underrun;

  fmw_encoder u_fmw_encoder (
    .clk(clk), .rst(rst), .wr_go(wr_go), .mode_mfm(mode_mfm),
    .cell_tick(cell_tick), .byte_data(byte_data), .byte_valid(byte_valid),
    .byte_ready(byte_ready), .wdata(wdata), .wen(wen), .mfm_ind(mfm_ind),
    .pre_early(pre_early), .pre_late(pre_late), .underrun(underrun)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [2:0] rec [0:1023];
  int rec_cnt = 0;
  int tick_ph = 0;
  logic [2:0] expc [0:511];
  logic [7:0] wb [0:16];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        finish_run();
      end
    end
  end

  // Tick every four clocks; record outputs after each tick edge
  initial begin
    forever begin
      @(negedge clk);
      cell_tick = (tick_ph == 0);
      if (tick_ph == 1 && wen && rec_cnt < 1024) begin
        rec[rec_cnt] = {wdata, pre_early, pre_late};
        rec_cnt++;
      end
      tick_ph = (tick_ph + 1) % 4;
    end
  end

  // Expected cells for nb payload bytes followed by lookahead byte wb[nb]
  function automatic void build_exp(input int nb, input bit mfm);
    logic [135:0] bits;
    for (int i = 0; i <= nb; i++)
      for (int j = 0; j < 8; j++) bits[i*8 + j] = wb[i][7-j];
    for (int k = 0; k < nb * 8; k++) begin
      logic prv, d, nx;
      prv = (k == 0) ? 1'b0 : bits[k-1];
      d   = bits[k];
      nx  = bits[k+1];
      expc[2*k]   = {mfm ? (~prv & ~d) : 1'b1, 2'b00};
      expc[2*k+1] = {d, mfm & d & prv & ~nx, mfm & d & ~prv & nx};
    end
  endfunction

  task automatic push_byte(input logic [7:0] b);
    @(negedge clk);
    byte_data = b;
    byte_valid = 1'b1;
    while (!byte_ready) @(negedge clk);
    @(negedge clk);
    byte_valid = 1'b0;
  endtask

  // One write of nb bytes plus padding; pad=0 withholds the padding byte
  task automatic run_write(input int nb, input bit mfm, input bit flip,
                           input bit pad, input string tag);
    int cells, target, w;
    build_exp(nb, mfm);
    cells = nb * 16;
    target = mfm ? cells : 2 * cells;
    @(negedge clk);
    mode_mfm = mfm;
    repeat (4) @(negedge clk);
    chk(mfm_ind == mfm, {tag, " R7 idle mode"}, mfm_ind, mfm);
    rec_cnt = 0;
    wr_go = 1'b1;
    repeat (2) @(negedge clk);
    chk(byte_ready == 1'b1, {tag, " R8 ready"}, byte_ready, 1);
    fork
      begin
        for (int i = 0; i < nb; i++) push_byte(wb[i]);
        if (pad) push_byte(wb[nb]);
      end
      begin
        if (flip) begin
          w = 0;
          while (rec_cnt < 4 && w < 20000) begin @(negedge clk); w++; end
          mode_mfm = ~mfm;
        end
        w = 0;
        while (rec_cnt < target && w < 40000) begin @(negedge clk); w++; end
        chk(mfm_ind == mfm, {tag, " R7 held mode"}, mfm_ind, mfm);
        wr_go = 1'b0;
      end
    join
    repeat (12) @(negedge clk);
    chk(wen == 1'b0, {tag, " R6 wen off"}, wen, 0);
    chk(rec_cnt == target, {tag, " R6 R5 cell count"}, rec_cnt, target);
    for (int k = 0; k < cells; k++) begin
      if (mfm) begin
        chk(rec[k] == expc[k], {tag, (k % 2) ? " R3 R4 data cell" : " R3 clock cell"},
            rec[k], expc[k]);
      end else begin
        chk(rec[2*k] == expc[k] && rec[2*k+1] == expc[k],
            {tag, " R2 R5 fm cell"}, {rec[2*k], rec[2*k+1]}, {expc[k], expc[k]});
      end
    end
    if (flip) mode_mfm = mfm;
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk({wen, wdata, pre_early, pre_late, underrun, byte_ready, mfm_ind} == 7'b0,
        "R1 reset outputs", {wen, wdata, pre_early, pre_late, underrun, byte_ready, mfm_ind}, 0);
    byte_valid = 1'b1;
    byte_data = 8'h5A;
    repeat (3) @(negedge clk);
    chk(byte_ready == 1'b0, "R8 no ready without gate", byte_ready, 0);
    chk(wen == 1'b0, "R8 no start without gate", wen, 0);
    byte_valid = 1'b0;

    wb[0] = 8'h00; wb[1] = 8'hFF; wb[2] = 8'hA5; wb[3] = 8'h3C;
    run_write(3, 1'b0, 1'b0, 1'b1, "fm directed");
    wb[0] = 8'h00; wb[1] = 8'hFF; wb[2] = 8'h55; wb[3] = 8'hAA;
    wb[4] = 8'h66; wb[5] = 8'h99; wb[6] = 8'hB4;
    run_write(6, 1'b1, 1'b0, 1'b1, "mfm directed");
    chk(underrun == 1'b0, "R9 no underrun when fed", underrun, 0);
    wb[0] = 8'h6D; wb[1] = 8'h92; wb[2] = 8'hE1; wb[3] = 8'h0F;
    run_write(3, 1'b1, 1'b1, 1'b1, "mfm mode flip");
    wb[0] = 8'hC8; wb[1] = 8'h13; wb[2] = 8'h77;
    run_write(2, 1'b0, 1'b1, 1'b1, "fm mode flip");

    for (int t = 0; t < 10; t++) begin
      int nb;
      nb = 1 + int'($urandom % 6);
      for (int i = 0; i <= nb; i++) wb[i] = 8'($urandom);
      run_write(nb, 1'($urandom), 1'b0, 1'b1, "random");
    end
    chk(underrun == 1'b0, "R9 still clear", underrun, 0);

    wb[0] = 8'hC3; wb[1] = 8'h00; wb[2] = 8'h00; wb[3] = 8'h00;
    run_write(3, 1'b1, 1'b0, 1'b0, "underrun zeros R9");
    chk(underrun == 1'b1, "R9 underrun set", underrun, 1);
    repeat (20) @(negedge clk);
    chk(underrun == 1'b1, "R9 underrun sticky", underrun, 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(underrun == 1'b0, "R1 R9 reset clears flag", underrun, 0);
    finish_run();
  end

endmodule